// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, frame by frame, whether a frame is kept. It watches the first six bytes of each frame, which are the destination address. As the bytes stream in, it compares them with the configured station address and with the all-ones broadcast address. One cycle after the sixth byte it presents a single-cycle decision: accept or reject, together with a code that names the rule that decided.

Software supplies the station address as three 16-bit halves. The filter control word has separate enables for exact-match and broadcast acceptance. A pass-all bit in the MAC configuration word overrides the filter so that every frame is kept. Hash filtering, wake-up detection and CRC checking belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is applied and after its release, `dec_valid_o` is 0. Whenever `dec_valid_o` is 0, `accept_o` is 0 and `match_o` is 0.
- R2: Destination byte k (k = 0 is the first byte received) is compared with a fixed part of the station address registers:
  - `sta_hi_i[7:0]` holds byte 0 and `sta_hi_i[15:8]` holds byte 1.
  - `sta_mid_i[7:0]` holds byte 2 and `sta_mid_i[15:8]` holds byte 3.
  - `sta_lo_i[7:0]` holds byte 4 and `sta_lo_i[15:8]` holds byte 5.
- R3: When `flt_ctrl_i[5]` is 1 and all six destination bytes equal the station address, the frame is accepted with `match_o` = 1 (exact).
- R4: When `flt_ctrl_i[1]` is 1 and all six destination bytes are 0xFF, the frame is accepted with `match_o` = 2 (broadcast).
- R5: When `mac_cfg_i[1]` is 1, every frame is accepted with `match_o` = 3 (pass-all), whatever the filter enables are.
- R6: When several rules hold, the one reported is chosen in this order: pass-all first, then exact, then broadcast.
- R7: The decision appears on `dec_valid_o` for exactly one cycle, in the cycle after the clock edge that takes the sixth destination byte. It is never raised earlier in the frame.
- R8: A byte that has `byte_valid_i` and `sof_i` both set is taken as byte 0 of a new frame. Any partial comparison is discarded, and an interrupted frame yields no decision. `sof_i` without `byte_valid_i` has no effect.
- R9: After the sixth byte, further valid bytes without `sof_i` are ignored and produce no decision until the next `sof_i`.
- R10: When `mac_cfg_i[1]`, `flt_ctrl_i[1]` and `flt_ctrl_i[5]` are all 0, every frame is rejected with `match_o` = 0.
- R11: A single differing byte at any of the six positions defeats an exact match or a broadcast match. The frame is then rejected with `match_o` = 0, unless another enabled rule holds.
- R12: Cycles with `byte_valid_i` low do not advance the byte position, so idle gaps between bytes do not change the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Marks the valid byte as the first byte of a frame |
| byte_valid_i | input | 1 | `byte_i` carries a frame byte this cycle |
| byte_i | input | 8 | Received byte |
| sta_hi_i | input | 16 | Station address bytes 0 (low half) and 1 (high half) |
| sta_mid_i | input | 16 | Station address bytes 2 (low half) and 3 (high half) |
| sta_lo_i | input | 16 | Station address bytes 4 (low half) and 5 (high half) |
| flt_ctrl_i | input | 16 | Filter control: bit 1 enables broadcast, bit 5 enables exact match |
| mac_cfg_i | input | 16 | MAC configuration: bit 1 selects pass-all |
| dec_valid_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted; valid with `dec_valid_o` |
| match_o | output | 2 | Deciding rule: 0 none, 1 exact, 2 broadcast, 3 pass-all |

## Verification
The hardest case to reach is a comparison that fails at exactly one byte position while all the other bytes match. It must be tried at each of the six positions, both against the station address and against the broadcast pattern. The bench covers it by sweeping every position with single-bit flips at both ends of the byte.

Two more cases are hard to see at the ports: a frame cut short by a fresh start strobe, and bytes that trail a completed address. The bench drives them directly and checks that no stray strobe appears. A station address set to all ones makes the exact and broadcast rules hold together, which exposes the priority between them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES   = 6;
  localparam int BYTE_W       = 8;
  localparam int HALF_W       = 2 * BYTE_W;
  localparam int IDX_W        = $clog2(ADDR_BYTES + 1);
  localparam int BCAST_BIT    = 1;
  localparam int EXACT_BIT    = 5;
  localparam int PASS_ALL_BIT = 1;

  typedef enum logic [1:0] {
    MATCH_NONE  = 2'd0,
    MATCH_EXACT = 2'd1,
    MATCH_BCAST = 2'd2,
    MATCH_ALL   = 2'd3
  } match_e;
endpackage

// File: rtl/rxf_byte_seq.sv
module rxf_byte_seq
  import rxf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  output logic             take_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] DONE = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ADDR_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic             start;

  assign start   = valid_i & sof_i;
  assign take_o  = valid_i & (sof_i | (idx_q != DONE));
  assign idx_o   = start ? '0 : idx_q;
  assign first_o = start;
  assign last_o  = take_o & (idx_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= DONE;
    else if (take_o) idx_q <= idx_o + 1'b1;
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == DONE && !start) |=> idx_q == DONE);
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> idx_q == IDX_W'(1));
  // R12
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(idx_q));
endmodule

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp
  import rxf_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [ADDR_BYTES-1:0][BYTE_W-1:0]   sta_i,
  input  logic [BYTE_W-1:0]                   byte_i,
  input  logic                                take_i,
  input  logic                                first_i,
  input  logic [IDX_W-1:0]                    idx_i,
  output logic                                exact_o,
  output logic                                bcast_o
);
  logic [ADDR_BYTES-1:0] eq_vec;
  logic                  sta_eq, ones;
  logic                  exact_q, bcast_q;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_eq
    assign eq_vec[g] = (byte_i == sta_i[g]);
  end

  assign sta_eq  = (idx_i < IDX_W'(ADDR_BYTES)) ? eq_vec[idx_i] : 1'b0;
  assign ones    = &byte_i;
  // running result including the byte presented this cycle
  assign exact_o = (first_i | exact_q) & sta_eq;
  assign bcast_o = (first_i | bcast_q) & ones;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exact_q <= 1'b0;
      bcast_q <= 1'b0;
    end else if (take_i) begin
      exact_q <= exact_o;
      bcast_q <= bcast_o;
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       last_i,
  input  logic       exact_i,
  input  logic       bcast_i,
  input  logic       pass_all_i,
  input  logic       exact_en_i,
  input  logic       bcast_en_i,
  output logic       dec_valid_o,
  output logic       accept_o,
  output logic [1:0] match_o
);
  match_e rule;

  always_comb begin
    if (pass_all_i)                rule = MATCH_ALL;
    else if (exact_en_i & exact_i) rule = MATCH_EXACT;
    else if (bcast_en_i & bcast_i) rule = MATCH_BCAST;
    else                           rule = MATCH_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      match_o     <= MATCH_NONE;
    end else begin
      dec_valid_o <= last_i;
      accept_o    <= last_i & (rule != MATCH_NONE);
      match_o     <= last_i ? rule : MATCH_NONE;
    end
  end

  // R7
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
  // R7
  after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(last_i));
  // R1
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (!accept_o && match_o == MATCH_NONE));
  // R5
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && pass_all_i) |=> (accept_o && match_o == MATCH_ALL));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sof_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic [15:0] sta_hi_i,
  input  logic [15:0] sta_mid_i,
  input  logic [15:0] sta_lo_i,
  input  logic [15:0] flt_ctrl_i,
  input  logic [15:0] mac_cfg_i,
  output logic        dec_valid_o,
  output logic        accept_o,
  output logic [1:0]  match_o
);
  localparam int N_HALF = ADDR_BYTES / 2;

  logic [N_HALF-1:0][HALF_W-1:0]     sta_regs;
  logic [ADDR_BYTES-1:0][BYTE_W-1:0] sta_bytes;
  logic                              take, first, last, exact, bcast;
  logic [IDX_W-1:0]                  idx;

  assign sta_regs = {sta_hi_i, sta_mid_i, sta_lo_i};

  // pair k lives in register N_HALF-1-k, earlier byte in the low half
  for (genvar k = 0; k < N_HALF; k++) begin : g_pair
    assign sta_bytes[2*k]   = sta_regs[N_HALF-1-k][BYTE_W-1:0];
    assign sta_bytes[2*k+1] = sta_regs[N_HALF-1-k][HALF_W-1:BYTE_W];
  end

  rxf_byte_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (byte_valid_i),
    .sof_i   (sof_i),
    .take_o  (take),
    .first_o (first),
    .last_o  (last),
    .idx_o   (idx)
  );

  rxf_addr_cmp u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sta_i   (sta_bytes),
    .byte_i  (byte_i),
    .take_i  (take),
    .first_i (first),
    .idx_i   (idx),
    .exact_o (exact),
    .bcast_o (bcast)
  );

  rxf_decide u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .last_i      (last),
    .exact_i     (exact),
    .bcast_i     (bcast),
    .pass_all_i  (mac_cfg_i[PASS_ALL_BIT]),
    .exact_en_i  (flt_ctrl_i[EXACT_BIT]),
    .bcast_en_i  (flt_ctrl_i[BCAST_BIT]),
    .dec_valid_o (dec_valid_o),
    .accept_o    (accept_o),
    .match_o     (match_o)
  );
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0;
  logic [7:0]  dat = '0;
  logic [15:0] sta_hi, sta_mid, sta_lo, flt, cfg;
  logic        dv, acc;
  logic [1:0]  mt;
  int          total = 0, bad = 0;
  bit          done = 0;
  logic [5:0][7:0] sta;

  always #5 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(vld), .byte_i(dat),
    .sta_hi_i(sta_hi), .sta_mid_i(sta_mid), .sta_lo_i(sta_lo),
    .flt_ctrl_i(flt), .mac_cfg_i(cfg),
    .dec_valid_o(dv), .accept_o(acc), .match_o(mt)
  );

  // R2 register placement computed from byte list
  always_comb begin
    sta_hi  = {sta[1], sta[0]};
    sta_mid = {sta[3], sta[2]};
    sta_lo  = {sta[5], sta[4]};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [5:0][7:0] f);
    if (cfg[1]) return 2'd3;
    if (flt[5] && f == sta) return 2'd1;
    if (flt[1] && f == {6{8'hFF}}) return 2'd2;
    return 2'd0;
  endfunction

  task automatic send(input logic [5:0][7:0] f, input bit gap, input string req);
    logic [1:0] e;
    bit early;
    e = model(f);
    early = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sof = (i == 0); vld = 1'b1; dat = f[i];
      @(posedge clk); #1;
      if (i < 5 && dv) early = 1;
      if (gap && i < 5) begin
        @(negedge clk); sof = 1'b0; vld = 1'b0; dat = 8'hFF;
        @(posedge clk); #1;
        if (dv) early = 1;
      end
    end
    chk(!early, {req, " R7 early"}, early, 0);
    chk(dv === 1'b1, {req, " R7 valid"}, dv, 1);
    chk(mt === e, {req, " match"}, mt, e);
    chk(acc === (e != 0), {req, " accept"}, acc, e != 0);
    @(negedge clk); sof = 1'b0; vld = 1'b0;
    @(posedge clk); #1;
    chk(dv === 1'b0 && acc === 1'b0 && mt === 2'd0, {req, " R7/R1 pulse end"}, dv, 0);
  endtask

  // bytes without a completed decision; sof marks byte 0 when first is set
  task automatic drive_loose(input int n, input bit first, input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sof = first && (i == 0); vld = 1'b1; dat = sta[i % 6];
      @(posedge clk); #1;
      if (dv) seen = 1;
    end
    @(negedge clk); sof = 1'b0; vld = 1'b0;
    @(posedge clk); #1;
    if (dv) seen = 1;
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0][7:0] f;
    sta = {8'h6F, 8'h5E, 8'h4D, 8'h3C, 8'h1A, 8'h02};
    flt = '0; cfg = '0;
    repeat (3) @(posedge clk);
    #1 chk(dv === 1'b0 && acc === 1'b0 && mt === 2'd0, "R1 in reset", dv, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(dv === 1'b0 && acc === 1'b0 && mt === 2'd0, "R1 after reset", dv, 0);

    // R3 R4 R5 R6 R10: all enable combinations against three frame kinds
    for (int c = 0; c < 8; c++) begin
      cfg = 16'(c[2]) << 1;
      flt = (16'(c[1]) << 5) | (16'(c[0]) << 1);
      send(sta, 0, "R3/R5/R10 station");
      send({6{8'hFF}}, 0, "R4/R5/R10 bcast");
      send({8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h11}, 0, "R5/R10 other");
    end

    // R11 R2: single-byte mismatch sweep, exact and broadcast enabled
    cfg = '0; flt = 16'h0022;
    for (int p = 0; p < 6; p++) begin
      for (int b = 0; b < 2; b++) begin
        f = sta; f[p] = f[p] ^ (b ? 8'h80 : 8'h01);
        send(f, 0, "R11 exact miss");
        f = {6{8'hFF}}; f[p] = f[p] ^ (b ? 8'h80 : 8'h01);
        send(f, 0, "R11 bcast miss");
      end
    end
    // R2: swapped bytes inside each register pair must not match
    f = {sta[4], sta[5], sta[2], sta[3], sta[0], sta[1]};
    send(f, 0, "R2 swapped halves");

    // R12 gaps
    send(sta, 1, "R12 gap station");
    flt = 16'h0002;
    send({6{8'hFF}}, 1, "R12 gap bcast");

    // R8 interrupted frame then full frame
    flt = 16'h0020;
    drive_loose(3, 1, "R8 partial no decision");
    send(sta, 0, "R8 restart");
    // R8 sof without valid is inert: hold sof alone mid-frame
    @(negedge clk); sof = 1'b1; vld = 1'b1; dat = sta[0];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk); sof = 1'b1; vld = 1'b0; dat = 8'h00;
      @(negedge clk); sof = 1'b0; vld = 1'b1; dat = sta[i];
    end
    @(posedge clk); #1;
    chk(dv === 1'b1 && mt === 2'd1, "R8 lone sof ignored", mt, 1);
    @(negedge clk); vld = 1'b0;

    // R9 trailing bytes ignored
    send(sta, 0, "R9 frame");
    drive_loose(8, 0, "R9 trailing bytes");

    // R6 station equals broadcast: exact wins
    sta = {6{8'hFF}}; flt = 16'h0022;
    send({6{8'hFF}}, 0, "R6 exact over bcast");
    cfg = 16'h0002;
    send({6{8'hFF}}, 0, "R6 pass-all first");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule